// File: doc/BRIEF.md
# Timebase transfer target decoder

This block sits beside the chip's time-of-day controller. Software writes it a control word that names the core whose timebase should receive the time value. The block decodes that word into a stored target, which is a valid flag plus a core index. Software then issues a move command. If the controller is running, the command bit is set and a target is stored, the block raises a per-core "sent" indication toward the selected core. It does this only when that core reports that it is ready to receive. The indication stays up until the core acknowledges it.

A control word names its target in one of two ways. The first is a full bus address: an upper page, which is matched against a per-core table of base pages, plus a register field that must name the timebase register. The second is a short core identifier. The `BUS_ONLY` parameter selects the variant that accepts only bus addressing. A decode that finds no target is reported when the control word is written. A move that is refused, or that finds its core not ready, is reported when the move is written.

Top module: `tbx_target_dec`

## Requirements
- R1: After reset the stored target is invalid, all `sent` bits are 0 and all four error outputs are 0.
- R2: A write to offset 0x27 with `wr_data[28]` = 1 selects bus addressing. A target is valid when `wr_data[43:32]` equals 0x4A3 and `wr_data[63:44]` equals the base page of some core.
- R3: In bus addressing, a register field other than 0x4A3 stores an invalid target and pulses `err_target` for one cycle after the write.
- R4: In bus addressing, if no core's base page matches, the target is stored as invalid and `err_target` pulses. If several cores match, the lowest index is chosen.
- R5: With `BUS_ONLY` = 0 and `wr_data[28]` = 0, the core ID is `wr_data[36:32]`, which is the six-bit field `wr_data[37:32]` with its top bit masked off. An ID below `NCORES` is a valid target. Any other ID stores an invalid target and pulses `err_target`.
- R6: With `BUS_ONLY` = 1, a control word with `wr_data[28]` = 0 stores an invalid target and pulses both `err_target` and `err_unimpl`.
- R7: A write to offset 0x17 is accepted when all three of these hold: `ctl_state` equals the running code 2, `wr_data[63]` = 1, and the stored target is valid. If the target core's `core_ready` bit is 1, that core's `sent` bit is 1 from the next cycle and no error is raised.
- R8: A move that is not accepted pulses `err_reject` and leaves `sent` unchanged, apart from acknowledges.
- R9: An accepted move whose target core has `core_ready` = 0 pulses `err_notready` and sets no `sent` bit.
- R10: A `sent` bit holds until its `sent_ack` bit is 1. When a set and an acknowledge for the same core fall in the same cycle, the set wins.
- R11: Every control write replaces the stored target, including replacing a valid target with an invalid one.
- R12: Writes to any offset other than 0x27 and 0x17 change neither the target nor `sent`, and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | OFF_W | Register offset of the write |
| wr_data | input | 64 | Write data |
| ctl_state | input | STATE_W | Controller lifecycle state; 2 means running |
| core_ready | input | NCORES | Per-core ready-to-receive flags |
| core_base | input | NCORES*20 | Per-core base page (address bits 31:12); core i is at bits 20i+19:20i |
| sent_ack | input | NCORES | Per-core acknowledge that clears `sent` |
| sent | output | NCORES | Per-core time-value-sent indication |
| err_target | output | 1 | One-cycle pulse: the control word decoded to no target |
| err_unimpl | output | 1 | One-cycle pulse: the addressing mode is not supported by this variant |
| err_reject | output | 1 | One-cycle pulse: the move was refused |
| err_notready | output | 1 | One-cycle pulse: the move was accepted but the core was not ready |

## Verification
The assertions check the following on every cycle. A `sent` bit only rises after a running move that has its command bit set, and at most one rises at a time. Unacknowledged bits never drop. Each error pulse traces back to a write at the matching offset, and a not-ready move leaves `sent` alone. Only the bench scenarios can show that the decode picks the right core: the register-field check, page matching with lowest-index priority, masking of the core ID, and the bus-only variant's refusal. The same holds for replacing a target with an invalid one and for ignoring other offsets.

// File: rtl/tbx_target_dec.sv
module tbx_target_dec #(
  parameter int NCORES    = 8,
  parameter bit BUS_ONLY  = 1'b0,
  parameter int OFF_W     = 6,
  parameter int CTRL_OFF  = 'h27,
  parameter int MOVE_OFF  = 'h17,
  parameter int STATE_W   = 3,
  parameter int RUN_STATE = 2,
  parameter int TB_REG    = 'h4A3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [OFF_W-1:0]     wr_off,
  input  logic [63:0]          wr_data,
  input  logic [STATE_W-1:0]   ctl_state,
  input  logic [NCORES-1:0]    core_ready,
  input  logic [NCORES*20-1:0] core_base,
  input  logic [NCORES-1:0]    sent_ack,
  output logic [NCORES-1:0]    sent,
  output logic                 err_target,
  output logic                 err_unimpl,
  output logic                 err_reject,
  output logic                 err_notready
);
  localparam int IDX_W  = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam int PAGE_W = 20;

  logic ctrl_wr, move_wr, bus_mode;
  logic [PAGE_W-1:0] page;
  logic [11:0] reg_f;
  logic [4:0]  cid;

  assign ctrl_wr  = wr_en && (wr_off == OFF_W'(CTRL_OFF));
  assign move_wr  = wr_en && (wr_off == OFF_W'(MOVE_OFF));
  assign bus_mode = wr_data[28];
  assign page     = wr_data[63:44];
  assign reg_f    = wr_data[43:32];
  assign cid      = wr_data[36:32];

  wire unused_bits = ^{wr_data[31:29], wr_data[27:0]};

  logic [NCORES-1:0] page_hit;
  for (genvar g = 0; g < NCORES; g++) begin : g_hit
    assign page_hit[g] = (core_base[g*PAGE_W +: PAGE_W] == page);
  end

  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NCORES - 1; i >= 0; i--) begin
      if (page_hit[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  logic             id_ok, dec_valid, dec_unimpl;
  logic [IDX_W-1:0] dec_idx;
  assign id_ok = ({27'd0, cid} < 32'(NCORES));

  always_comb begin
    dec_valid  = 1'b0;
    dec_unimpl = 1'b0;
    dec_idx    = '0;
    if (bus_mode) begin
      dec_valid = (reg_f == 12'(TB_REG)) && hit_any;
      dec_idx   = hit_idx;
    end else if (BUS_ONLY) begin
      dec_unimpl = 1'b1;
    end else begin
      dec_valid = id_ok;
      dec_idx   = IDX_W'(cid);
    end
  end

  logic             tgt_valid;
  logic [IDX_W-1:0] tgt_idx;
  logic [NCORES-1:0] tgt_sel;
  always_comb begin
    for (int i = 0; i < NCORES; i++)
      tgt_sel[i] = tgt_valid && (tgt_idx == IDX_W'(i));
  end

  logic legal, rdy;
  logic [NCORES-1:0] set_vec;
  assign legal   = move_wr && (ctl_state == STATE_W'(RUN_STATE)) && wr_data[63] && tgt_valid;
  assign rdy     = |(core_ready & tgt_sel);
  assign set_vec = (legal && rdy) ? tgt_sel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_valid    <= 1'b0;
      tgt_idx      <= '0;
      sent         <= '0;
      err_target   <= 1'b0;
      err_unimpl   <= 1'b0;
      err_reject   <= 1'b0;
      err_notready <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        tgt_valid <= dec_valid;
        tgt_idx   <= dec_idx;
      end
      sent         <= (sent & ~sent_ack) | set_vec;
      err_target   <= ctrl_wr && !dec_valid;
      err_unimpl   <= ctrl_wr && dec_unimpl;
      err_reject   <= move_wr && !legal;
      err_notready <= legal && !rdy;
    end
  end
endmodule

module tbx_target_dec_chk #(
  parameter int NCORES    = 8,
  parameter int OFF_W     = 6,
  parameter int CTRL_OFF  = 'h27,
  parameter int MOVE_OFF  = 'h17,
  parameter int STATE_W   = 3,
  parameter int RUN_STATE = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [OFF_W-1:0]   wr_off,
  input logic               cmd_bit,
  input logic [STATE_W-1:0] ctl_state,
  input logic [NCORES-1:0]  sent_ack,
  input logic [NCORES-1:0]  sent,
  input logic               err_target,
  input logic               err_unimpl,
  input logic               err_reject,
  input logic               err_notready
);
  AST_SENT_NEEDS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sent & ~$past(sent))) |-> ($past(wr_en) && $past(wr_off) == OFF_W'(MOVE_OFF) &&
      $past(ctl_state) == STATE_W'(RUN_STATE) && $past(cmd_bit))); // R7
  AST_ONE_SENT_PER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sent & ~$past(sent)) <= 1); // R7
  AST_SENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sent) & ~$past(sent_ack) & ~sent) == '0)); // R10
  AST_UNIMPL_IS_TARGET_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_unimpl |-> err_target); // R6
  AST_TARGET_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_target |-> ($past(wr_en) && $past(wr_off) == OFF_W'(CTRL_OFF))); // R3
  AST_MOVE_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reject || err_notready) |-> ($past(wr_en) && $past(wr_off) == OFF_W'(MOVE_OFF))); // R8
  AST_NOTREADY_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_notready |-> (sent == ($past(sent) & ~$past(sent_ack)))); // R9
endmodule

bind tbx_target_dec tbx_target_dec_chk #(
  .NCORES(NCORES), .OFF_W(OFF_W), .CTRL_OFF(CTRL_OFF), .MOVE_OFF(MOVE_OFF),
  .STATE_W(STATE_W), .RUN_STATE(RUN_STATE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .cmd_bit(wr_data[63]),
  .ctl_state(ctl_state), .sent_ack(sent_ack), .sent(sent), .err_target(err_target),
  .err_unimpl(err_unimpl), .err_reject(err_reject), .err_notready(err_notready)
);

// File: tb/tbx_target_dec_test.sv
module tbx_target_dec_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_off = '0;
  logic [63:0] wr_data = '0;
  logic [2:0] ctl_state = 3'd2;
  logic [N-1:0] core_ready = 8'b1111_0111;
  logic [N*20-1:0] core_base;
  logic [N-1:0] sent_ack = '0;
  logic [N-1:0] sent_f, sent_b;
  logic [3:0] err_f, err_b;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  initial begin
    for (int i = 0; i < N; i++) core_base[i*20 +: 20] = 20'h10000 + 20'(i << 12);
    core_base[6*20 +: 20] = 20'h12000;
  end

  tbx_target_dec #(.NCORES(N), .BUS_ONLY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .ctl_state(ctl_state), .core_ready(core_ready), .core_base(core_base), .sent_ack(sent_ack),
    .sent(sent_f), .err_notready(err_f[3]), .err_reject(err_f[2]), .err_unimpl(err_f[1]),
    .err_target(err_f[0]));

  tbx_target_dec #(.NCORES(N), .BUS_ONLY(1'b1)) uut_bus (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .ctl_state(ctl_state), .core_ready(core_ready), .core_base(core_base), .sent_ack(sent_ack),
    .sent(sent_b), .err_notready(err_b[3]), .err_reject(err_b[2]), .err_unimpl(err_b[1]),
    .err_target(err_b[0]));

  // expected item: {sent_full, err_full, sent_bus, err_bus}; err = {notready, reject, unimpl, target}
  logic [23:0] exp_q[$];
  string tag_q[$];

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (wr_en) begin
      #1;
      if (exp_q.size() > 0) begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " full"}, {12'd0, sent_f, err_f}, {12'd0, e[23:12]});
        check({t, " bus-only"}, {12'd0, sent_b, err_b}, {12'd0, e[11:0]});
      end
    end
  end

  task automatic wr(input logic [5:0] off, input logic [63:0] d, input logic [2:0] st,
                    input logic [N-1:0] ack, input logic [7:0] sf, input logic [3:0] ef,
                    input logic [7:0] sb, input logic [3:0] eb, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = d; ctl_state = st; sent_ack = ack;
    exp_q.push_back({sf, ef, sb, eb});
    tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; sent_ack = '0; ctl_state = 3'd2;
  endtask

  task automatic ack_all(input string tag);
    @(negedge clk);
    sent_ack = '1;
    @(negedge clk);
    sent_ack = '0;
    check(tag, {8'd0, sent_f, sent_b}, 24'd0);
  endtask

  function automatic logic [63:0] busw(input logic [31:0] a);
    return {a, 32'h1000_0000};
  endfunction
  function automatic logic [63:0] idw(input logic [5:0] id);
    return {26'd0, id, 32'd0};
  endfunction
  localparam logic [63:0] MOVE = 64'h8000_0000_0000_0000;

  initial begin
    #(8 * 5000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {sent_f, err_f, sent_b, err_b}, 24'd0);

    wr(6'h17, MOVE, 3'd2, '0, 8'h00, 4'b0100, 8'h00, 4'b0100, "R1 R8 move without target");
    wr(6'h27, busw(32'h1100_04A3), 3'd2, '0, 8'h00, 4'b0000, 8'h00, 4'b0000, "R2 bus decode core1");
    wr(6'h17, MOVE, 3'd2, '0, 8'h02, 4'b0000, 8'h02, 4'b0000, "R7 move to core1");
    repeat (3) @(negedge clk);
    check("R10 sent held", {8'd0, sent_f, sent_b}, {8'd0, 8'h02, 8'h02});
    ack_all("R10 ack clears");

    wr(6'h27, busw(32'h1100_04A4), 3'd2, '0, 8'h00, 4'b0001, 8'h00, 4'b0001, "R3 wrong register");
    wr(6'h17, MOVE, 3'd2, '0, 8'h00, 4'b0100, 8'h00, 4'b0100, "R11 invalid replaced valid");
    wr(6'h27, busw(32'h7F00_04A3), 3'd2, '0, 8'h00, 4'b0001, 8'h00, 4'b0001, "R4 no page match");
    wr(6'h27, busw(32'h1200_04A3), 3'd2, '0, 8'h00, 4'b0000, 8'h00, 4'b0000, "R4 shared page");
    wr(6'h17, MOVE, 3'd2, '0, 8'h04, 4'b0000, 8'h04, 4'b0000, "R4 lowest index wins");
    ack_all("R4 ack");

    wr(6'h27, idw(6'h05), 3'd2, '0, 8'h00, 4'b0000, 8'h00, 4'b0011, "R5 R6 core id 5");
    wr(6'h17, MOVE, 3'd2, '0, 8'h20, 4'b0000, 8'h00, 4'b0100, "R5 R6 move by id");
    ack_all("R5 ack");
    wr(6'h27, idw(6'h23), 3'd2, '0, 8'h00, 4'b0000, 8'h00, 4'b0011, "R5 masked id 3");
    wr(6'h17, MOVE, 3'd2, '0, 8'h00, 4'b1000, 8'h00, 4'b0100, "R9 core not ready");
    wr(6'h27, idw(6'h09), 3'd2, '0, 8'h00, 4'b0001, 8'h00, 4'b0011, "R5 id out of range");
    wr(6'h27, idw(6'h26), 3'd2, '0, 8'h00, 4'b0000, 8'h00, 4'b0011, "R5 masked id 6");
    wr(6'h17, MOVE, 3'd2, '0, 8'h40, 4'b0000, 8'h00, 4'b0100, "R5 move to core6");
    ack_all("R5 ack core6");

    wr(6'h27, busw(32'h1400_04A3), 3'd2, '0, 8'h00, 4'b0000, 8'h00, 4'b0000, "R11 new target core4");
    wr(6'h17, MOVE, 3'd1, '0, 8'h00, 4'b0100, 8'h00, 4'b0100, "R8 not running");
    wr(6'h17, 64'h7FFF_FFFF_FFFF_FFFF, 3'd2, '0, 8'h00, 4'b0100, 8'h00, 4'b0100, "R8 command bit clear");
    wr(6'h11, busw(32'h1000_04A3), 3'd2, '0, 8'h00, 4'b0000, 8'h00, 4'b0000, "R12 other offset");
    wr(6'h17, MOVE, 3'd2, '0, 8'h10, 4'b0000, 8'h10, 4'b0000, "R12 target kept core4");
    wr(6'h17, MOVE, 3'd2, 8'h10, 8'h10, 4'b0000, 8'h10, 4'b0000, "R10 set wins over ack");
    ack_all("R10 final ack");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule